// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Rounding

This block is the arithmetic core of a signal-processing datapath. Each cycle it can multiply two signed fractional operands and either clear the accumulator, load it with the full product, add the product to it, or subtract the product from it. The accumulator carries extra headroom bits above the double-width product, so a long run of sums can grow past the range of a single product without wrapping. A multiply and its accumulation complete in one clock.

Whenever the caller asks for a result, the block reduces the accumulator to a single-width fraction. It can truncate, round half up, or round half to even. It can then either clamp a value that does not fit to the nearest extreme, or let it wrap. An overflow flag is captured with each stored result. Operands and results are two's-complement fractions with the binary point just right of the sign bit, so they span -1 up to just below +1. The accumulator keeps 2*DW-2 fraction bits, and a stored result keeps DW-1 fraction bits.

Top module: `fxp_mac`

## Requirements
- R1: While rstN is low, accOut, resultOut and ovfFlag are all zero.
- R2: When opValid is high at a rising edge, the accumulator is updated by opSel: 00 sets it to zero, 01 loads the signed product opA*opB, 10 adds the product, 11 subtracts the product. The new value appears on accOut after that edge.
- R3: The accumulator is 2*DW+GUARD bits wide and holds sums beyond the product range exactly, for example four products of (-1)*(-1).
- R4: When opValid is low, the accumulator keeps its value whatever opSel, opA and opB are.
- R5: When storeEn is high at a rising edge, resultOut and ovfFlag take the value derived from the accumulator as it was before that edge, even if the accumulator is updated at the same edge. When storeEn is low, both hold.
- R6: roundSel 00 truncates: the low DW-1 accumulator bits are dropped, which rounds toward minus infinity. roundSel 11 behaves the same way.
- R7: roundSel 01 rounds to nearest. One is added to the kept part when the dropped fraction is one half or more.
- R8: roundSel 10 is convergent rounding. It rounds up above one half and down below one half. At exactly one half it adds one only if the kept LSB is 1.
- R9: With satEn high, a rounded value above 2^(DW-1)-1 is stored as 2^(DW-1)-1, and one below -2^(DW-1) is stored as -2^(DW-1).
- R10: With satEn low, the stored result is the low DW bits of the rounded value, which wraps.
- R11: ovfFlag is stored as 1 exactly when the rounded value lies outside [-2^(DW-1), 2^(DW-1)-1], whether or not satEn is high. The extremes themselves give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | DW | Signed fractional operand A |
| opB | input | DW | Signed fractional operand B |
| opValid | input | 1 | Apply the accumulator operation this cycle |
| opSel | input | 2 | Operation: 00 clear, 01 load, 10 add, 11 subtract |
| roundSel | input | 2 | Rounding: 00 truncate, 01 nearest, 10 convergent, 11 truncate |
| satEn | input | 1 | Clamp out-of-range results instead of wrapping |
| storeEn | input | 1 | Capture the rounded accumulator into the result |
| accOut | output | 2*DW+GUARD | Full accumulator |
| resultOut | output | DW | Stored single-width result |
| ovfFlag | output | 1 | Overflow captured with the stored result |

## Verification
The bench builds the block with DW=8 and GUARD=4, which gives a 20-bit accumulator and 7 dropped fraction bits. With these values every product, rounding tie and clamp can be worked out by hand from small integers. Both full-scale extremes are reached: the (-1)*(-1) product, which overflows only once it is reduced, and negative sums below -1. Both also land exactly on the edges of the representable range, where no clamp must occur. Four guard bits give enough headroom to hold several full-scale sums that are beyond the product width.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'b00,
    OP_LOAD  = 2'b01,
    OP_ADD   = 2'b10,
    OP_SUB   = 2'b11
  } macOp_e;

  typedef enum logic [1:0] {
    RND_TRUNC     = 2'b00,
    RND_NEAREST   = 2'b01,
    RND_CONVERGE  = 2'b10,
    RND_TRUNC_ALT = 2'b11
  } rndMode_e;

  typedef struct packed {
    logic clear;
    logic load;
    logic add;
    logic sub;
    logic store;
  } macStb_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  logic [1:0] opSel,
  input  logic    storeEn,
  output macStb_t stb
);

  always_comb begin
    stb = '0;
    stb.store = storeEn;
    if (opValid) begin
      case (macOp_e'(opSel))
        OP_CLEAR: stb.clear = 1'b1;
        OP_LOAD:  stb.load  = 1'b1;
        OP_ADD:   stb.add   = 1'b1;
        OP_SUB:   stb.sub   = 1'b1;
        default:  stb.clear = 1'b0;
      endcase
    end
  end

  AST_ONE_ACC_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clear, stb.load, stb.add, stb.sub}) && (opValid == (|{stb.clear, stb.load, stb.add, stb.sub}))); // R2

endmodule

// File: rtl/mac_rounder.sv
module mac_rounder
  import mac_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic [ACCW-1:0] accIn,
  input  logic [1:0]      roundSel,
  input  logic            satEn,
  output logic [DW-1:0]   wordOut,
  output logic            outOfRange
);

  localparam int DROP  = DW - 1;
  localparam int KEEPW = ACCW - DROP;
  localparam int RW    = KEEPW + 1;

  localparam logic signed [RW-1:0] MAXV = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [RW-1:0] MINV = {{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAXW = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINW = {1'b1, {(DW-1){1'b0}}};

  logic [KEEPW-1:0]      kept;
  logic                  halfBit;
  logic                  sticky;
  logic                  incr;
  logic signed [RW-1:0]  rounded;

  assign kept    = accIn[ACCW-1:DROP];
  assign halfBit = accIn[DROP-1];
  assign sticky  = |accIn[DROP-2:0];

  always_comb begin
    case (rndMode_e'(roundSel))
      RND_NEAREST:  incr = halfBit;
      RND_CONVERGE: incr = halfBit & (sticky | kept[0]);
      default:      incr = 1'b0;
    endcase
  end

  assign rounded    = signed'({kept[KEEPW-1], kept}) + signed'({{(RW-1){1'b0}}, incr});
  assign outOfRange = (rounded > MAXV) || (rounded < MINV);

  always_comb begin
    if (satEn && outOfRange) wordOut = rounded[RW-1] ? MINW : MAXW;
    else                     wordOut = rounded[DW-1:0];
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  parameter int ACCW  = 2*DW + GUARD
) (
  input  logic            clk,
  input  logic            rstN,
  input  macStb_t         stb,
  input  logic [DW-1:0]   opA,
  input  logic [DW-1:0]   opB,
  input  logic            satEn,
  input  logic [DW-1:0]   roundedWord,
  input  logic            roundedOvf,
  output logic [ACCW-1:0] accQ,
  output logic [DW-1:0]   resultQ,
  output logic            ovfQ
);

  localparam int PW = 2 * DW;
  localparam logic [DW-1:0] MAXW = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINW = {1'b1, {(DW-1){1'b0}}};

  logic signed [PW-1:0] product;
  logic [ACCW-1:0]      productExt;

  assign product    = signed'(opA) * signed'(opB);
  assign productExt = {{GUARD{product[PW-1]}}, product};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          accQ <= '0;
    else if (stb.clear) accQ <= '0;
    else if (stb.load)  accQ <= productExt;
    else if (stb.add)   accQ <= accQ + productExt;
    else if (stb.sub)   accQ <= accQ - productExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      ovfQ    <= 1'b0;
    end else if (stb.store) begin
      resultQ <= roundedWord;
      ovfQ    <= roundedOvf;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.clear || stb.load || stb.add || stb.sub) |=> $stable(accQ)); // R4

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (accQ == '0)); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.store |=> ($stable(resultQ) && $stable(ovfQ))); // R5

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.store && satEn && roundedOvf) |=> (resultQ == MAXW || resultQ == MINW)); // R9

endmodule

// File: rtl/fxp_mac.sv
module fxp_mac
  import mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  localparam int ACCW = 2*DW + GUARD
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DW-1:0]   opA,
  input  logic [DW-1:0]   opB,
  input  logic            opValid,
  input  logic [1:0]      opSel,
  input  logic [1:0]      roundSel,
  input  logic            satEn,
  input  logic            storeEn,
  output logic [ACCW-1:0] accOut,
  output logic [DW-1:0]   resultOut,
  output logic            ovfFlag
);

  macStb_t         stb;
  logic [DW-1:0]   roundedWord;
  logic            roundedOvf;

  mac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opSel   (opSel),
    .storeEn (storeEn),
    .stb     (stb)
  );

  mac_rounder #(.DW(DW), .ACCW(ACCW)) u_rounder (
    .accIn      (accOut),
    .roundSel   (roundSel),
    .satEn      (satEn),
    .wordOut    (roundedWord),
    .outOfRange (roundedOvf)
  );

  mac_datapath #(.DW(DW), .GUARD(GUARD), .ACCW(ACCW)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .opA         (opA),
    .opB         (opB),
    .satEn       (satEn),
    .roundedWord (roundedWord),
    .roundedOvf  (roundedOvf),
    .accQ        (accOut),
    .resultQ     (resultOut),
    .ovfQ        (ovfFlag)
  );

endmodule

// File: tb/test_fxp_mac.sv
module test_fxp_mac;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int GUARD = 4;
  localparam int ACCW  = 2*DW + GUARD;
  localparam int NVEC  = 20;

  typedef struct packed {
    logic signed [7:0]  a;
    logic signed [7:0]  b;
    logic [1:0]         op;
    logic [1:0]         rnd;
    logic               sat;
    logic signed [19:0] expAcc;
    logic [7:0]         expRes;
    logic               expOvf;
  } vec_t;

  // op: 0 clear, 1 load, 2 add, 3 sub; rnd: 0 trunc, 1 nearest, 2 convergent, 3 trunc
  localparam vec_t VECS [NVEC] = '{
    '{8'sd64,   8'sd64,   2'd1, 2'd0, 1'b1,  20'sd4096,   8'h20, 1'b0},
    '{8'sd3,    8'sd43,   2'd1, 2'd1, 1'b1,  20'sd129,    8'h01, 1'b0},
    '{8'sd1,    8'sd64,   2'd1, 2'd2, 1'b1,  20'sd64,     8'h00, 1'b0},
    '{8'sd2,    8'sd64,   2'd2, 2'd2, 1'b1,  20'sd192,    8'h02, 1'b0},
    '{-8'sd1,   8'sd64,   2'd1, 2'd1, 1'b1, -20'sd64,     8'h00, 1'b0},
    '{-8'sd3,   8'sd1,    2'd1, 2'd0, 1'b1, -20'sd3,      8'hFF, 1'b0},
    '{-8'sd128, -8'sd128, 2'd1, 2'd0, 1'b1,  20'sd16384,  8'h7F, 1'b1},
    '{-8'sd128, -8'sd128, 2'd1, 2'd0, 1'b0,  20'sd16384,  8'h80, 1'b1},
    '{8'sd5,    8'sd5,    2'd0, 2'd0, 1'b1,  20'sd0,      8'h00, 1'b0},
    '{8'sd127,  8'sd127,  2'd3, 2'd1, 1'b1, -20'sd16129,  8'h82, 1'b0},
    '{-8'sd128, 8'sd127,  2'd3, 2'd2, 1'b1,  20'sd127,    8'h01, 1'b0},
    '{8'sd127,  8'sd127,  2'd3, 2'd0, 1'b1, -20'sd16002,  8'h82, 1'b0},
    '{8'sd127,  8'sd127,  2'd3, 2'd0, 1'b1, -20'sd32131,  8'h80, 1'b1},
    '{8'sd1,    8'sd64,   2'd1, 2'd3, 1'b1,  20'sd64,     8'h00, 1'b0},
    '{8'sd127,  8'sd127,  2'd1, 2'd1, 1'b1,  20'sd16129,  8'h7E, 1'b0},
    '{8'sd1,    8'sd127,  2'd2, 2'd0, 1'b1,  20'sd16256,  8'h7F, 1'b0},
    '{8'sd1,    8'sd64,   2'd2, 2'd1, 1'b1,  20'sd16320,  8'h7F, 1'b1},
    '{8'sd0,    8'sd0,    2'd2, 2'd2, 1'b0,  20'sd16320,  8'h80, 1'b1},
    '{8'sd127,  -8'sd128, 2'd1, 2'd0, 1'b1, -20'sd16256,  8'h81, 1'b0},
    '{-8'sd1,   8'sd127,  2'd2, 2'd0, 1'b1, -20'sd16383,  8'h80, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [DW-1:0]   opA = '0;
  logic [DW-1:0]   opB = '0;
  logic            opValid = 1'b0;
  logic [1:0]      opSel = '0;
  logic [1:0]      roundSel = '0;
  logic            satEn = 1'b0;
  logic            storeEn = 1'b0;
  logic [ACCW-1:0] accOut;
  logic [DW-1:0]   resultOut;
  logic            ovfFlag;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxp_mac #(.DW(DW), .GUARD(GUARD)) i_fxp_mac (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .opValid   (opValid),
    .opSel     (opSel),
    .roundSel  (roundSel),
    .satEn     (satEn),
    .storeEn   (storeEn),
    .accOut    (accOut),
    .resultOut (resultOut),
    .ovfFlag   (ovfFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [7:0] a, input logic [7:0] b, input logic [1:0] op);
    @(negedge clk);
    opA = a; opB = b; opSel = op; opValid = 1'b1; storeEn = 1'b0;
  endtask

  task automatic doStore(input logic [1:0] rnd, input logic sat);
    @(negedge clk);
    opValid = 1'b0; storeEn = 1'b1; roundSel = rnd; satEn = sat;
    @(negedge clk);
    storeEn = 1'b0;
  endtask

  function automatic string resTag(input vec_t v);
    if (v.expOvf) return v.sat ? "R9 result" : "R10 result";
    case (v.rnd)
      2'd1:    return "R7 result";
      2'd2:    return "R8 result";
      default: return "R6 result";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int accHold;
    int resHold;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 accOut", int'($signed(accOut)), 0);
    chk("R1 resultOut", int'(resultOut), 0);
    chk("R1 ovfFlag", int'(ovfFlag), 0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      doOp(VECS[i].a, VECS[i].b, VECS[i].op);
      doStore(VECS[i].rnd, VECS[i].sat);
      chk($sformatf("R2 accOut vec%0d", i), int'($signed(accOut)), int'(VECS[i].expAcc));
      chk($sformatf("%s vec%0d", resTag(VECS[i]), i), int'(resultOut), int'(VECS[i].expRes));
      chk($sformatf("R11 ovfFlag vec%0d", i), int'(ovfFlag), int'(VECS[i].expOvf));
    end

    // R4: opValid low leaves the accumulator untouched
    accHold = int'($signed(accOut));
    @(negedge clk);
    opA = 8'sd100; opB = 8'sd100; opSel = 2'd1; opValid = 1'b0; storeEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R4 accOut held", int'($signed(accOut)), accHold);

    // R5: no store keeps result; store in same cycle as update uses old value
    resHold = int'(resultOut);
    doOp(8'sd64, 8'sd64, 2'd1);
    @(negedge clk);
    opValid = 1'b0;
    chk("R5 result held", int'(resultOut), resHold);
    chk("R5 acc loaded", int'($signed(accOut)), 4096);
    @(negedge clk);
    opA = 8'sd64; opB = 8'sd64; opSel = 2'd2; opValid = 1'b1;
    storeEn = 1'b1; roundSel = 2'd0; satEn = 1'b1;
    @(negedge clk);
    opValid = 1'b0; storeEn = 1'b0;
    chk("R5 result from old acc", int'(resultOut), 32);
    chk("R5 acc updated same edge", int'($signed(accOut)), 8192);

    // R3: guard bits hold sums well beyond the product range
    doOp(8'h80, 8'h80, 2'd1);
    doOp(8'h80, 8'h80, 2'd2);
    doOp(8'h80, 8'h80, 2'd2);
    doOp(8'h80, 8'h80, 2'd2);
    doStore(2'd0, 1'b1);
    chk("R3 accOut guard", int'($signed(accOut)), 65536);
    chk("R9 result guard sum", int'(resultOut), 127);
    chk("R11 ovf guard sum", int'(ovfFlag), 1);
    doOp(8'h7F, 8'h80, 2'd1);
    doOp(8'h7F, 8'h80, 2'd2);
    doOp(8'h7F, 8'h80, 2'd2);
    doOp(8'h7F, 8'h80, 2'd2);
    doStore(2'd0, 1'b0);
    chk("R3 accOut guard negative", int'($signed(accOut)), -65024);
    chk("R10 result wrap negative", int'(resultOut), 8'h04);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule